// File: doc/BRIEF.md
# Bus Controller Frame and Gap Timer

This block is the timing engine of a serial-bus controller. It keeps two countdowns, both derived from the system clock through a microsecond prescaler. The major-frame countdown runs in 100 µs steps and marks the end of each frame. The message-gap countdown runs in 1 µs steps and tells the protocol sequencer when the next message may start. Both remaining values can be read by the host at any time.

The host programs the frame length and the next gap through a small write port, then issues start or stop commands. The protocol sequencer reports each finished message with a one-cycle pulse. The timer loads the programmed gap at that point, and when the gap has run out it sends back a one-cycle start-next-message pulse. At each frame boundary the block raises an end-of-frame interrupt pulse. With auto-repeat selected it then begins the next frame on its own. The prescaler divides by 12 or by 16, so one build serves either core clock rate.

Top module: `bc_frame_timer`

## Requirements
- R1: After reset, `frame_left`, `gap_left`, `running`, `start_frame`, `start_msg` and `irq_vec` are all zero.
- R2: A write with `wr_sel`=2 (start) loads `frame_left` with the programmed frame time (written with `wr_sel`=0) and sets `running`. In the cycle after the write, `start_frame` is high for exactly one cycle.
- R3: While running, `frame_left` falls by one every 100·D clock cycles after the start write, where D is the prescaler divisor.
- R4: When `frame_left` reaches zero, bit 3 of `irq_vec` pulses high for one cycle, exactly F·100·D cycles after the start write, where F is the frame time. All other bits of `irq_vec` stay zero.
- R5: If `wr_data[0]` was 1 on the start write and the frame time is nonzero, the frame restarts at expiry. In the cycle of the end-of-frame pulse, `start_frame` also pulses, `frame_left` equals F again and `running` stays 1. The next end-of-frame follows F·100·D cycles later.
- R6: Without auto-repeat, once the frame expires `running` is 0 and `frame_left` is 0, and `start_frame` does not pulse again.
- R7: A frame time of zero disables auto-repeat. The frame is started once, `running` stays 1 and no end-of-frame pulse occurs.
- R8: A `msg_done` pulse while running loads `gap_left` with the gap written with `wr_sel`=1. `gap_left` then falls by one every D cycles, and `start_msg` pulses for one cycle exactly G·D cycles after the `msg_done` cycle, where G is the gap.
- R9: With a gap of zero, `start_msg` pulses in the cycle right after `msg_done`.
- R10: A write with `wr_sel`=3 (stop) clears `running`. Both countdowns then hold their values and no pulse is produced.
- R11: `msg_done` has no effect while not running: `gap_left` is unchanged and `start_msg` does not pulse.
- R12: `clk_sel_fast`=1 selects D=16 and `clk_sel_fast`=0 selects D=12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_fast | input | 1 | Prescaler select: 1 divides by 16, 0 divides by 12 |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 frame time, 1 gap, 2 start, 3 stop |
| wr_data | input | 16 | Write value; bit 0 on start selects auto-repeat |
| msg_done | input | 1 | One-cycle pulse from the sequencer when a message ends |
| running | output | 1 | Frame timing active |
| frame_left | output | 16 | Frame time remaining, 100 µs per LSB |
| gap_left | output | 16 | Time until next message, 1 µs per LSB |
| start_frame | output | 1 | One-cycle pulse at each frame start |
| start_msg | output | 1 | One-cycle pulse to launch the next message |
| irq_vec | output | 16 | Interrupt source pulses; bit 3 is end of frame |

## Verification
Every result is registered once. `start_frame`, `frame_left` and `running` change on the edge that samples the start write. The end-of-frame pulse is due exactly F·100·D edges after that write. `gap_left` loads on the `msg_done` edge, and `start_msg` follows G·D edges later. The bench drives on falling edges and counts these edge numbers from the stimulus edge. It checks each pulse one cycle before it is due, where it must still be low, and again in its due cycle, so an off-by-one in a prescaler or a countdown is detected.

// File: rtl/bc_timer_pkg.sv
package bc_timer_pkg;

  typedef enum logic [1:0] {
    HOST_FRAME_TIME = 2'd0,
    HOST_GAP_TIME   = 2'd1,
    HOST_START      = 2'd2,
    HOST_STOP       = 2'd3
  } host_sel_e;

  localparam int US_PER_FRAME_LSB = 100;

endpackage

// File: rtl/bc_tick_div.sv
module bc_tick_div #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] term,
  output logic          tick
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  assign tick = en && !clr && (cnt_q >= term);

  always_comb begin
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (en) begin
      cnt_n = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/bc_frame_ctl.sv
module bc_frame_ctl #(
  parameter int FW  = 16,
  parameter int PW  = 4,
  parameter int SUB = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_time,
  input  logic [FW-1:0] time_in,
  input  logic          start,
  input  logic          repeat_req,
  input  logic          stop,
  input  logic [PW-1:0] us_term,
  output logic          running,
  output logic [FW-1:0] frame_left,
  output logic          start_frame,
  output logic          eof
);

  localparam int SW = $clog2(SUB);

  logic [FW-1:0] time_q, time_n;
  logic [FW-1:0] left_q, left_n;
  logic          auto_q, auto_n;
  logic          run_q, run_n;
  logic          sf_q, sf_n;
  logic          eof_q, eof_n;
  logic          us_tick;
  logic          frame_tick;

  bc_tick_div #(.CW(PW)) u_us_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .en    (run_q),
    .term  (us_term),
    .tick  (us_tick)
  );

  bc_tick_div #(.CW(SW)) u_sub_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .en    (us_tick),
    .term  (SW'(SUB - 1)),
    .tick  (frame_tick)
  );

  always_comb begin
    time_n = ld_time ? time_in : time_q;
    left_n = left_q;
    auto_n = auto_q;
    run_n  = run_q;
    sf_n   = 1'b0;
    eof_n  = 1'b0;
    if (start) begin
      run_n  = 1'b1;
      left_n = time_q;
      auto_n = repeat_req && (time_q != '0);
      sf_n   = 1'b1;
    end else if (stop) begin
      run_n  = 1'b0;
    end else if (run_q && frame_tick && (left_q != '0)) begin
      if (left_q == FW'(1)) begin
        eof_n = 1'b1;
        if (auto_q && (time_q != '0)) begin
          left_n = time_q;
          sf_n   = 1'b1;
        end else begin
          left_n = '0;
          run_n  = 1'b0;
          auto_n = 1'b0;
        end
      end else begin
        left_n = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      left_q <= '0;
      auto_q <= 1'b0;
      run_q  <= 1'b0;
      sf_q   <= 1'b0;
      eof_q  <= 1'b0;
    end else begin
      time_q <= time_n;
      left_q <= left_n;
      auto_q <= auto_n;
      run_q  <= run_n;
      sf_q   <= sf_n;
      eof_q  <= eof_n;
    end
  end

  assign running     = run_q;
  assign frame_left  = left_q;
  assign start_frame = sf_q;
  assign eof         = eof_q;

  AST_EOF_ONCE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q && !sf_q |-> (left_q == '0) && !run_q); // R6

  AST_REPEAT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q && sf_q |-> (left_q != '0) && run_q); // R5

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && frame_tick && (left_q > FW'(1)) && !start && !stop
      |=> left_q == $past(left_q) - 1'b1); // R3

  AST_FRAME_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !start |=> $stable(left_q)); // R10

endmodule

// File: rtl/bc_gap_ctl.sv
module bc_gap_ctl #(
  parameter int GW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_gap,
  input  logic [GW-1:0] gap_in,
  input  logic          msg_done,
  input  logic          running,
  input  logic [PW-1:0] us_term,
  output logic [GW-1:0] gap_left,
  output logic          start_msg
);

  logic [GW-1:0] gap_q, gap_n;
  logic [GW-1:0] left_q, left_n;
  logic          sm_q, sm_n;
  logic          accept;
  logic          us_tick;

  assign accept = msg_done && running;

  bc_tick_div #(.CW(PW)) u_gap_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (running),
    .term  (us_term),
    .tick  (us_tick)
  );

  always_comb begin
    gap_n  = ld_gap ? gap_in : gap_q;
    left_n = left_q;
    sm_n   = 1'b0;
    if (accept) begin
      left_n = gap_q;
      sm_n   = (gap_q == '0);
    end else if (running && us_tick && (left_q != '0)) begin
      left_n = left_q - 1'b1;
      sm_n   = (left_q == GW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      left_q <= '0;
      sm_q   <= 1'b0;
    end else begin
      gap_q  <= gap_n;
      left_q <= left_n;
      sm_q   <= sm_n;
    end
  end

  assign gap_left  = left_q;
  assign start_msg = sm_q;

  AST_LAUNCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sm_q |-> (left_q == '0)); // R8

  AST_GAP_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(left_q) && !sm_q); // R11

endmodule

// File: rtl/bc_frame_timer.sv
module bc_frame_timer #(
  parameter int FRAME_W  = 16,
  parameter int GAP_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 16,
  parameter int IRQ_W    = 16,
  parameter int EOF_BIT  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_sel_fast,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [15:0]        wr_data,
  input  logic               msg_done,
  output logic               running,
  output logic [FRAME_W-1:0] frame_left,
  output logic [GAP_W-1:0]   gap_left,
  output logic               start_frame,
  output logic               start_msg,
  output logic [IRQ_W-1:0]   irq_vec
);

  import bc_timer_pkg::*;

  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int PW      = $clog2(DIV_MAX);

  host_sel_e     sel;
  logic          wr_frame, wr_gap, wr_start, wr_stop;
  logic [PW-1:0] us_term;
  logic          eof;

  assign sel      = host_sel_e'(wr_sel);
  assign wr_frame = wr_en && (sel == HOST_FRAME_TIME);
  assign wr_gap   = wr_en && (sel == HOST_GAP_TIME);
  assign wr_start = wr_en && (sel == HOST_START);
  assign wr_stop  = wr_en && (sel == HOST_STOP);
  assign us_term  = clk_sel_fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);

  bc_frame_ctl #(
    .FW  (FRAME_W),
    .PW  (PW),
    .SUB (US_PER_FRAME_LSB)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_time     (wr_frame),
    .time_in     (FRAME_W'(wr_data)),
    .start       (wr_start),
    .repeat_req  (wr_data[0]),
    .stop        (wr_stop),
    .us_term     (us_term),
    .running     (running),
    .frame_left  (frame_left),
    .start_frame (start_frame),
    .eof         (eof)
  );

  bc_gap_ctl #(
    .GW (GAP_W),
    .PW (PW)
  ) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_gap    (wr_gap),
    .gap_in    (GAP_W'(wr_data)),
    .msg_done  (msg_done),
    .running   (running),
    .us_term   (us_term),
    .gap_left  (gap_left),
    .start_msg (start_msg)
  );

  always_comb begin
    irq_vec          = '0;
    irq_vec[EOF_BIT] = eof;
  end

  AST_IRQ_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_vec) && (irq_vec[EOF_BIT] || (irq_vec == '0))); // R4

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stop |=> !running && !start_frame && !start_msg); // R10

endmodule

// File: tb/bc_frame_timer_tb.sv
module bc_frame_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_sel_fast = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        msg_done = 1'b0;
  logic        running;
  logic [15:0] frame_left;
  logic [15:0] gap_left;
  logic        start_frame;
  logic        start_msg;
  logic [15:0] irq_vec;

  int n_tests = 0;
  int n_fail  = 0;
  int n_eof   = 0;
  int n_sf    = 0;
  int n_sm    = 0;

  always #2.5 clk = ~clk;

  bc_frame_timer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel_fast (clk_sel_fast),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .msg_done     (msg_done),
    .running      (running),
    .frame_left   (frame_left),
    .gap_left     (gap_left),
    .start_frame  (start_frame),
    .start_msg    (start_msg),
    .irq_vec      (irq_vec)
  );

  always @(negedge clk) begin
    if (irq_vec[3]) n_eof++;
    if (start_frame) n_sf++;
    if (start_msg) n_sm++;
  end

  // {sel_fast, frame time, gap} per entry
  localparam logic [23:0] VEC [4] = '{
    {8'd0, 8'd1, 8'd10},
    {8'd1, 8'd1, 8'd25},
    {8'd0, 8'd2, 8'd40},
    {8'd1, 8'd2, 8'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'd0;
  endtask

  task automatic pulse_done();
    msg_done = 1'b1;
    @(negedge clk);
    msg_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int snap_eof, snap_sm, snap_sf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 frame_left", frame_left, 0);
    chk("R1 gap_left", gap_left, 0);
    chk("R1 running", running, 0);
    chk("R1 pulses", {start_frame, start_msg}, 0);
    chk("R1 irq_vec", irq_vec, 0);

    for (int i = 0; i < 4; i++) begin
      int d, f, g;
      clk_sel_fast = VEC[i][16];
      d = VEC[i][16] ? 16 : 12;              // R12 divisor
      f = int'(VEC[i][15:8]);
      g = int'(VEC[i][7:0]);
      host_wr(2'd0, 16'(f));
      host_wr(2'd1, 16'(g));
      host_wr(2'd2, 16'd0);
      chk("R2 start_frame", start_frame, 1);
      chk("R2 frame_left", frame_left, f);
      chk("R2 running", running, 1);
      pulse_done();
      chk("R8 gap loaded", gap_left, g);
      repeat (g * d - 1) @(negedge clk);
      chk("R8 R12 start_msg early", start_msg, 0);
      @(negedge clk);
      chk("R8 R12 start_msg due", start_msg, 1);
      chk("R8 gap_left zero", gap_left, 0);
      snap_sf = n_sf;
      repeat (f * 100 * d - (1 + g * d) - 1) @(negedge clk);
      chk("R4 R12 eof early", irq_vec, 0);
      @(negedge clk);
      chk("R4 eof due", irq_vec, 16'h0008);
      chk("R6 running off", running, 0);
      chk("R6 frame_left zero", frame_left, 0);
      repeat (20) @(negedge clk);
      chk("R6 no restart", n_sf, snap_sf);
    end

    // R3 step, then R10 stop holds
    clk_sel_fast = 1'b0;
    host_wr(2'd0, 16'd3);
    host_wr(2'd1, 16'd200);
    host_wr(2'd2, 16'd0);
    repeat (1199) @(negedge clk);
    chk("R3 before step", frame_left, 3);
    @(negedge clk);
    chk("R3 after step", frame_left, 2);
    pulse_done();
    chk("R8 gap load 200", gap_left, 200);
    repeat (60) @(negedge clk);
    chk("R8 gap step", gap_left, 195);
    host_wr(2'd3, 16'd0);
    chk("R10 running", running, 0);
    snap_eof = n_eof; snap_sm = n_sm; snap_sf = n_sf;
    repeat (3000) @(negedge clk);
    chk("R10 frame hold", frame_left, 2);
    chk("R10 gap hold", gap_left, 195);
    chk("R10 no pulses", n_eof + n_sm + n_sf, snap_eof + snap_sm + snap_sf);

    // R11 msg_done while stopped
    host_wr(2'd1, 16'd5);
    pulse_done();
    chk("R11 gap unchanged", gap_left, 195);
    repeat (100) @(negedge clk);
    chk("R11 no start_msg", n_sm, snap_sm);

    // R5 auto-repeat
    host_wr(2'd0, 16'd1);
    host_wr(2'd2, 16'd1);
    chk("R5 first start", start_frame, 1);
    repeat (1200) @(negedge clk);
    chk("R5 eof 1", irq_vec, 16'h0008);
    chk("R5 restart pulse", start_frame, 1);
    chk("R5 reload", frame_left, 1);
    chk("R5 running", running, 1);
    repeat (1199) @(negedge clk);
    chk("R5 eof 2 early", irq_vec, 0);
    @(negedge clk);
    chk("R5 eof 2", irq_vec, 16'h0008);
    chk("R5 restart 2", start_frame, 1);
    host_wr(2'd3, 16'd0);

    // R7 zero frame time, R9 zero gap
    host_wr(2'd0, 16'd0);
    host_wr(2'd1, 16'd0);
    host_wr(2'd2, 16'd1);
    chk("R7 start once", start_frame, 1);
    chk("R7 frame_left", frame_left, 0);
    pulse_done();
    chk("R9 start_msg next", start_msg, 1);
    chk("R9 gap_left", gap_left, 0);
    snap_eof = n_eof; snap_sf = n_sf;
    repeat (4000) @(negedge clk);
    chk("R7 no eof", n_eof, snap_eof);
    chk("R7 no restart", n_sf, snap_sf);
    chk("R7 running", running, 1);
    host_wr(2'd3, 16'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule